// File: doc/BRIEF.md
# Multiplexed Nibble Bus Memory Target

This block is a synchronous slave for memory read and memory write cycles on a 4-bit multiplexed address/data bus. A frame strobe with a zero start nibble opens a cycle. One nibble gives the cycle type, eight nibbles carry a 32-bit address with the most significant nibble first, and a write then carries one byte as two nibbles. After the host's turnaround, the target answers with a one-clock ready sync code. For a read it then drives the byte, and it closes the cycle with its own turnaround.

Only two fixed address windows are claimed: a 4 MiB region at the top of the 32-bit space and a 128 KiB region just below 1 MiB. Accesses outside both windows are ignored silently. On the memory side the block issues a one-clock request with address, direction and write byte. It samples the read byte in that same clock. While the memory reports itself busy, a read shows bit 7 inverted from the last byte written, so the host can poll for completion.

The bus is split into an input nibble, an output nibble and an output enable. The pad that merges them lies outside this block.

Top module: `lpc_mem_target`

## Requirements
- R1: While reset is low, and after it, until a new cycle is claimed, the output enable and the memory request are both low.
- R2: A cycle opens on a clock with the frame strobe low and input nibble 0000b. The next nibble selects the type: 010xb is a read, 011xb is a write, and any other value makes the target ignore the cycle.
- R3: The next eight nibbles form the address, bits 31:28 first and bits 3:0 last. This address appears on the memory address output while the request is high.
- R4: For a write, the two nibbles after the address form the byte, bits 3:0 first. That byte appears on the write-data output with the write flag high during the request.
- R5: The target leaves the bus undriven for the two host turnaround clocks after the host's last nibble. It then drives 0000b for exactly one clock, and that clock is the one where the request is high.
- R6: For a read, the target drives the byte in the two clocks after the sync, bits 3:0 first. The byte is the read data sampled in the request clock.
- R7: After the sync (write) or after the second data nibble (read), the target drives 1111b for one clock and then releases the bus.
- R8: A cycle is claimed only if its address lies in FFC00000h..FFFFFFFFh or in 000E0000h..000FFFFFh. Otherwise the bus is never driven and no request is made.
- R9: If the memory busy input is high in the request clock of a read, bit 7 of the returned byte is the inverse of bit 7 of the last claimed write (0 after reset) and bits 6:0 come from the read data. If busy is low, the byte is the read data unchanged.
- R10: A clock with the frame strobe low aborts any cycle in progress. If that clock also carries 0000b, it starts a new cycle; otherwise the target goes idle.
- R11: Each claimed cycle raises the memory request for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe |
| busIn | input | 4 | Nibble sampled from the bus |
| busOut | output | 4 | Nibble driven by the target |
| busOe | output | 1 | Target drives busOut onto the bus |
| memReq | output | 1 | One-clock memory access request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Assembled cycle address |
| memWdata | output | 8 | Assembled write byte |
| memRdata | input | 8 | Read byte, sampled in the request clock |
| memBusy | input | 1 | Internal program or erase in progress |

## Verification
Reads and writes are issued with addresses at the edges of both windows and just past those edges. This separates correct window comparison from off-by-one errors and swapped bounds. The write byte and the read byte are asymmetric (for example 3Ch against C3h), so a swapped nibble order shows up. Reads are repeated with busy high and low after writes whose bit 7 differs, which separates the polled bit from plain read data. Aborts with and without a zero nibble, an unsupported type nibble, and a reset in mid-read show that restart and idle paths never leave the bus driven.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int ADDR_NIB = ADDR_W / NIB_W;
  localparam int DATA_NIB = DATA_W / NIB_W;
  localparam int CNT_W    = $clog2(ADDR_NIB);

  typedef enum logic [3:0] {
    S_IDLE, S_TYPE, S_ADDR, S_WDAT, S_TAR1, S_TAR2,
    S_SYNC, S_RDAT, S_ETAR1, S_ETAR2
  } state_e;

  typedef enum logic [1:0] {DRV_NONE, DRV_SYNC, DRV_DATA, DRV_ONES} drv_e;

  typedef struct packed {
    logic             shiftAddr;
    logic             shiftWr;
    logic             captureRd;
    logic             commitWr;
    drv_e             drive;
    logic [CNT_W-1:0] nibSel;
  } strobe_t;
endpackage

// File: rtl/lpc_tgt_ctrl.sv
module lpc_tgt_ctrl
  import lpc_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] busIn,
  input  logic       winHit,
  output strobe_t    stb,
  output logic       memReq,
  output logic       memWrite
);
  localparam logic [3:0] START_NIB = 4'b0000;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else if (!frameN) begin
      state <= (busIn == START_NIB) ? S_TYPE : S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_TYPE: begin
          if (busIn[3:2] == 2'b01) begin
            isWrite <= busIn[1];
            state   <= S_ADDR;
          end else begin
            state <= S_IDLE;
          end
          cnt <= '0;
        end
        S_ADDR: begin
          if (cnt == CNT_W'(ADDR_NIB - 1)) begin
            cnt   <= '0;
            state <= !winHit ? S_IDLE : (isWrite ? S_WDAT : S_TAR1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WDAT: begin
          if (cnt == CNT_W'(DATA_NIB - 1)) begin
            cnt   <= '0;
            state <= S_TAR1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TAR1: state <= S_TAR2;
        S_TAR2: state <= S_SYNC;
        S_SYNC: begin
          cnt   <= '0;
          state <= isWrite ? S_ETAR1 : S_RDAT;
        end
        S_RDAT: begin
          if (cnt == CNT_W'(DATA_NIB - 1)) begin
            cnt   <= '0;
            state <= S_ETAR1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ETAR1: state <= S_ETAR2;
        S_ETAR2: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.drive  = DRV_NONE;
    stb.nibSel = cnt;
    case (state)
      S_ADDR:  stb.shiftAddr = 1'b1;
      S_WDAT:  stb.shiftWr   = 1'b1;
      S_SYNC: begin
        stb.captureRd = !isWrite;
        stb.commitWr  = isWrite;
        stb.drive     = DRV_SYNC;
      end
      S_RDAT:  stb.drive = DRV_DATA;
      S_ETAR1: stb.drive = DRV_ONES;
      default: ;
    endcase
  end

  assign memReq   = (state == S_SYNC);
  assign memWrite = (state == S_SYNC) && isWrite;

  AST_TYPE_LEADS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && state == S_TYPE && busIn[3:2] == 2'b01) |=> stb.shiftAddr); // R2
endmodule

// File: rtl/lpc_tgt_dp.sv
module lpc_tgt_dp
  import lpc_tgt_pkg::*;
#(
  parameter int                      NUM_WIN  = 2,
  parameter logic [NUM_WIN*32-1:0]   WIN_BASE = {32'h000E_0000, 32'hFFC0_0000},
  parameter logic [NUM_WIN*32-1:0]   WIN_LAST = {32'h000F_FFFF, 32'hFFFF_FFFF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busIn,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memBusy,
  output logic              winHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [3:0]        busOut,
  output logic              busOe
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrQ;
  logic [DATA_W-1:0] rdQ;
  logic              lastBit7Q;
  logic [ADDR_W-1:0] nextAddr;
  logic [NUM_WIN-1:0] hitVec;
  logic [DATA_W-1:0] rdShift;

  assign nextAddr = {addrQ[ADDR_W-NIB_W-1:0], busIn};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hitVec[w] = (nextAddr >= WIN_BASE[w*32 +: 32]) &&
                       (nextAddr <= WIN_LAST[w*32 +: 32]);
  end
  assign winHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      wrQ       <= '0;
      rdQ       <= '0;
      lastBit7Q <= 1'b0;
    end else begin
      if (stb.shiftAddr) addrQ <= nextAddr;
      if (stb.shiftWr)   wrQ   <= {busIn, wrQ[DATA_W-1:NIB_W]};
      if (stb.commitWr)  lastBit7Q <= wrQ[DATA_W-1];
      if (stb.captureRd)
        rdQ <= memBusy ? {~lastBit7Q, memRdata[DATA_W-2:0]} : memRdata;
    end
  end

  assign rdShift  = rdQ >> {stb.nibSel, 2'b00};
  assign memAddr  = addrQ;
  assign memWdata = wrQ;
  assign busOe    = (stb.drive != DRV_NONE);

  always_comb begin
    case (stb.drive)
      DRV_DATA: busOut = rdShift[3:0];
      DRV_ONES: busOut = 4'hF;
      default:  busOut = 4'h0;
    endcase
  end

  AST_CLAIM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.captureRd || stb.commitWr) |->
      ((addrQ >= 32'hFFC0_0000) || (addrQ >= 32'h000E_0000 && addrQ <= 32'h000F_FFFF))); // R8
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        busIn,
  output logic [3:0]        busOut,
  output logic              busOe,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memBusy
);
  strobe_t stb;
  logic    winHit;

  lpc_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .busIn(busIn), .winHit(winHit),
    .stb(stb), .memReq(memReq), .memWrite(memWrite)
  );

  lpc_tgt_dp u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .stb(stb), .memRdata(memRdata),
    .memBusy(memBusy), .winHit(winHit), .memAddr(memAddr), .memWdata(memWdata),
    .busOut(busOut), .busOe(busOe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!busOe && !memReq)); // R1
  AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R11
  AST_SYNC_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (busOe && busOut == 4'h0)); // R5
  AST_FRAME_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !busOe); // R10
  AST_WRITE_TURNS_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && frameN) |=> (busOe && busOut == 4'hF)); // R7
endmodule

// File: tb/lpc_mem_target_tb.sv
module lpc_mem_target_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic [3:0]  busIn = 4'hF;
  logic [3:0]  busOut;
  logic        busOe, memReq, memWrite, memBusy = 1'b0;
  logic [31:0] memAddr;
  logic [7:0]  memWdata, memRdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit last7 = 1'b0;

  typedef struct {
    logic frameN; logic [3:0] nib; logic oe; logic [3:0] out;
    logic req; logic wr; logic [31:0] addr; logic [7:0] wdat; string tag;
  } cyc_t;
  cyc_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  assign memRdata = memAddr[7:0] ^ 8'hC3;

  lpc_mem_target u_dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memBusy(memBusy)
  );

  function automatic bit inWin(logic [31:0] a);
    return (a >= 32'hFFC0_0000) || (a >= 32'h000E_0000 && a <= 32'h000F_FFFF);
  endfunction

  task automatic push(logic f, logic [3:0] n, logic oe, logic [3:0] o,
                      logic rq, logic w, logic [31:0] a, logic [7:0] d, string t);
    cyc_t c;
    c.frameN = f; c.nib = n; c.oe = oe; c.out = o; c.req = rq; c.wr = w;
    c.addr = a; c.wdat = d; c.tag = t;
    expQ.push_back(c);
  endtask

  task automatic idle(string t);
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, t);
  endtask

  task automatic check(bit ok, string t, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // one bus cycle per queue entry: inputs set and outputs compared mid-clock
  task automatic runQueue(int limit);
    int n = 0;
    while (expQ.size() > 0 && n < limit) begin
      cyc_t c = expQ.pop_front();
      @(negedge clk);
      check(busOe === c.oe, c.tag, "busOe", busOe, c.oe);
      if (c.oe) check(busOut === c.out, c.tag, "busOut", busOut, c.out);
      check(memReq === c.req, c.tag, "memReq", memReq, c.req);
      if (c.req) begin
        check(memAddr === c.addr, c.tag, "memAddr", memAddr, c.addr);
        check(memWrite === c.wr, c.tag, "memWrite", memWrite, c.wr);
        if (c.wr) check(memWdata === c.wdat, c.tag, "memWdata", memWdata, c.wdat);
      end
      frameN = c.frameN;
      busIn  = c.nib;
      n++;
    end
  endtask

  task automatic head(logic [3:0] typ, logic [31:0] a, int nAddr);
    push(0, 4'h0, 0, 0, 0, 0, 0, 0, "R2");
    push(1, typ, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < nAddr; i++)
      push(1, a[31-4*i -: 4], 0, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic buildWrite(logic [31:0] a, logic [7:0] d);
    head(4'b0110, a, 8);
    if (!inWin(a)) begin
      push(1, d[3:0], 0, 0, 0, 0, 0, 0, "R8");
      push(1, d[7:4], 0, 0, 0, 0, 0, 0, "R8");
      for (int i = 0; i < 6; i++) idle("R8");
      return;
    end
    push(1, d[3:0], 0, 0, 0, 0, 0, 0, "R4");
    push(1, d[7:4], 0, 0, 0, 0, 0, 0, "R4");
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, "R5");
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, "R5");
    push(1, 4'hF, 1, 4'h0, 1, 1, a, d, "R4");
    push(1, 4'hF, 1, 4'hF, 0, 0, 0, 0, "R7");
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, "R7");
    idle("R11");
    last7 = d[7];
  endtask

  task automatic buildRead(logic [31:0] a, string dTag);
    logic [7:0] raw = a[7:0] ^ 8'hC3;
    logic [7:0] exp = memBusy ? {~last7, raw[6:0]} : raw;
    head(4'b0101, a, 8);
    if (!inWin(a)) begin
      for (int i = 0; i < 8; i++) idle("R8");
      return;
    end
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, "R5");
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, "R5");
    push(1, 4'hF, 1, 4'h0, 1, 0, a, 0, "R5");
    push(1, 4'hF, 1, exp[3:0], 0, 0, 0, 0, dTag);
    push(1, 4'hF, 1, exp[7:4], 0, 0, 0, 0, dTag);
    push(1, 4'hF, 1, 4'hF, 0, 0, 0, 0, "R7");
    push(1, 4'hF, 0, 0, 0, 0, 0, 0, "R7");
    idle("R11");
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busOe && !memReq, "R1", "reset outputs", {busOe, memReq}, 0);
    rstN = 1'b1;
    idle("R1"); idle("R1"); runQueue(1000);

    // main function, both windows and their edges
    buildWrite(32'hFFC0_0000, 8'h3C);  runQueue(1000);
    buildRead (32'hFFFF_FFFF, "R6");   runQueue(1000);
    buildWrite(32'h000E_0000, 8'hA5);  runQueue(1000);
    buildRead (32'h000F_FFFF, "R6");   runQueue(1000);
    buildRead (32'h000E_1234, "R6");   runQueue(1000);
    // just outside the windows
    buildRead (32'hFFBF_FFFF, "R8");   runQueue(1000);
    buildWrite(32'h000D_FFFF, 8'h77);  runQueue(1000);
    buildRead (32'h0010_0000, "R8");   runQueue(1000);

    // data poll: last write bit7 = 1
    buildWrite(32'hFFC1_0000, 8'h80);  runQueue(1000);
    memBusy = 1'b1;
    buildRead (32'hFFC1_0000, "R9");   runQueue(1000);
    memBusy = 1'b0;
    buildRead (32'hFFC1_0000, "R9");   runQueue(1000);
    buildWrite(32'h000E_0010, 8'h12);  runQueue(1000);
    memBusy = 1'b1;
    buildRead (32'h000E_00F0, "R9");   runQueue(1000);
    memBusy = 1'b0;

    // unsupported type nibble
    head(4'b0000, 32'hFFC0_0004, 8);
    for (int i = 0; i < 10; i++) idle("R2");
    runQueue(1000);

    // abort with a new start mid-address
    head(4'b0101, 32'hFFFF_0000, 3);
    buildWrite(32'hFFF0_1100, 8'h5E);  runQueue(1000);
    // abort with a non-zero nibble: rest of the cycle must be ignored
    head(4'b0101, 32'hFFFF_0040, 2);
    push(0, 4'h5, 0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 14; i++) push(1, 4'h0, 0, 0, 0, 0, 0, 0, "R10");
    runQueue(1000);
    buildRead (32'hFFF0_1100, "R10");  runQueue(1000);

    // reset in the middle of read data
    buildRead (32'hFFC0_0020, "R6");
    runQueue(14);
    expQ.delete();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!busOe && !memReq, "R1", "mid-cycle reset", {busOe, memReq}, 0);
    frameN = 1'b1; busIn = 4'hF;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    idle("R1"); idle("R1");
    buildRead (32'hFFC0_0020, "R1");   runQueue(1000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule